// File: doc/BRIEF.md
# Push-Button Debounce Validator

This block turns a raw mechanical push-button level into a clean, glitch-free level in the system clock domain. The button contacts are assumed to bounce: one physical press or release can show up as a burst of rapid on/off transitions lasting several milliseconds. The raw pin is asynchronous to the clock. It first crosses into the clock domain through a two-stage synchronizer.

A candidate change is never passed straight to the output. While the synchronized input disagrees with the currently accepted level, a qualification counter runs. Any return to the accepted level restarts it from zero. Only when the disagreement has lasted a full, unbroken settling window does the accepted level flip.

Each accepted press, meaning a change from released to pressed, also produces a single-cycle pulse. A downstream block can use that pulse as a one-shot event. The window is derived from the clock frequency and a settling time in milliseconds, which defaults to 20 ms. A cycle-count override lets a short window be used where that is convenient.

Top module: `btn_debounce`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `btn_level` is 0 (released) and `btn_press` is 0.
- R2: The raw input passes through two flip-flops before it is compared. A change of `btn_raw` that remains stable therefore changes `btn_level` on exactly the (WIN+2)-th rising clock edge after the change, and on no earlier edge.
- R3: WIN is `WIN_CYCLES` when that parameter is nonzero. Otherwise it is (`CLK_HZ`/1000)·`SETTLE_MS`, which is 20 ms by default. The accepted level changes only after the synchronized input has differed from it for WIN consecutive cycles.
- R4: Any cycle in which the synchronized input equals the accepted level restarts qualification from zero. A raw excursion lasting WIN-1 cycles leaves `btn_level` unchanged. An excursion lasting exactly WIN cycles is accepted.
- R5: A burst of bounces, each shorter than WIN, that ends at the pressed level yields exactly one `btn_press` pulse. That pulse comes WIN+2 edges after the last raw transition.
- R6: `btn_press` is high for exactly one cycle, in the cycle where `btn_level` goes from 0 to 1, and at no other time.
- R7: An accepted release drives `btn_level` from 1 to 0 with the same timing as a press, and it produces no `btn_press` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Raw, asynchronous, bouncing button level (1 = pressed) |
| btn_level | output | 1 | Debounced accepted level (1 = pressed) |
| btn_press | output | 1 | One-cycle pulse on an accepted press |

## Verification
The bench builds the block with `CLK_HZ` = 100 MHz and `WIN_CYCLES` = 200, so WIN is 200 cycles instead of the two million cycles of the 20 ms default. This brings both sides of the qualification boundary within reach: excursions of 199 and 200 cycles, bounce bursts of many sub-window pulses, and clean presses and releases, all inside a few thousand cycles. The exact edge of each level change and press pulse can then be predicted and compared against the design.

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned SETTLE_MS  = 20,
  parameter int unsigned WIN_CYCLES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic btn_level,
  output logic btn_press
);

  localparam int unsigned WIN   = (WIN_CYCLES != 0) ? WIN_CYCLES : (CLK_HZ / 1000) * SETTLE_MS;
  localparam int unsigned CNT_W = (WIN > 1) ? $clog2(WIN) : 1;

  logic             meta_q, sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differ, accept;

  assign differ = sync_q != btn_level;
  assign accept = differ && (cnt_q == CNT_W'(WIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= btn_raw;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      btn_level <= 1'b0;
      btn_press <= 1'b0;
    end else begin
      btn_press <= accept && !btn_level;
      if (accept) begin
        cnt_q     <= '0;
        btn_level <= sync_q;
      end else if (differ) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        cnt_q <= '0;
      end
    end
  end

endmodule

// File: rtl/btn_debounce_chk.sv
module btn_debounce_chk #(
  parameter int unsigned WIN   = 2,
  parameter int unsigned CNT_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             btn_level,
  input logic             btn_press
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(WIN)); // R3

  AST_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_level != $past(btn_level)) |-> ($past(cnt_q) == CNT_W'(WIN - 1))); // R3

  AST_RESTART_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q == btn_level) |=> (cnt_q == '0)); // R4

  AST_PRESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    btn_press |=> !btn_press); // R6

  AST_PRESS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    btn_press |-> (btn_level && !$past(btn_level))); // R6

  AST_RISE_HAS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(btn_level) |-> btn_press); // R5

  AST_NO_PRESS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(btn_level) |-> !btn_press); // R7

  always_comb if (!rst_n) AST_RESET_CLEAR: assert (!btn_press || $isunknown(btn_press)); // R1

endmodule

bind btn_debounce btn_debounce_chk #(.WIN(WIN), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .cnt_q(cnt_q),
  .btn_level(btn_level), .btn_press(btn_press)
);

// File: tb/btn_debounce_tb_top.sv
module btn_debounce_tb_top;
  localparam int W = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_raw = 1'b0;
  logic btn_level, btn_press;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  btn_debounce #(.CLK_HZ(100_000_000), .SETTLE_MS(20), .WIN_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw),
    .btn_level(btn_level), .btn_press(btn_press)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drive(input bit v, output int c0);
    btn_raw = v;
    c0 = cyc;
  endtask

  // scoreboard monitor: every pulse must match a queued expected cycle
  always @(negedge clk) begin
    if (mon_en && btn_press) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R7 unexpected press", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R6 press cycle", cyc, e);
      end
    end
  end

  initial begin
    repeat (2000 + 200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int c0, c1;
    repeat (3) @(negedge clk);
    check(btn_level == 1'b0, "R1 level in reset", btn_level, 0);
    check(btn_press == 1'b0, "R1 press in reset", btn_press, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(btn_level == 1'b0, "R1 level after reset", btn_level, 0);
    mon_en = 1'b1;

    // R4: excursion of W-1 cycles rejected
    drive(1'b1, c0);
    wait_cyc(c0 + W - 1);
    drive(1'b0, c1);
    wait_cyc(c1 + W + 10);
    check(btn_level == 1'b0, "R4 short glitch ignored", btn_level, 0);

    // R2/R3: clean press, exact acceptance edge
    drive(1'b1, c0);
    exp_q.push_back(c0 + W + 2);
    wait_cyc(c0 + W + 1);
    check(btn_level == 1'b0, "R2 level before window ends", btn_level, 0);
    wait_cyc(c0 + W + 2);
    check(btn_level == 1'b1, "R3 level at acceptance edge", btn_level, 1);
    check(btn_press == 1'b1, "R6 press with rising level", btn_press, 1);
    wait_cyc(c0 + W + 3);
    check(btn_press == 1'b0, "R6 press one cycle", btn_press, 0);
    wait_cyc(c0 + W + 50);

    // R4: release glitch of W-1 cycles rejected while pressed
    drive(1'b0, c0);
    wait_cyc(c0 + W - 1);
    drive(1'b1, c1);
    wait_cyc(c1 + W + 10);
    check(btn_level == 1'b1, "R4 release glitch ignored", btn_level, 1);

    // R7: clean release, no pulse
    drive(1'b0, c0);
    wait_cyc(c0 + W + 1);
    check(btn_level == 1'b1, "R7 level before release accepted", btn_level, 1);
    wait_cyc(c0 + W + 2);
    check(btn_level == 1'b0, "R7 release accepted", btn_level, 0);
    check(btn_press == 1'b0, "R7 no press on release", btn_press, 0);
    wait_cyc(c0 + W + 40);

    // R5: bounce burst then settle pressed -> exactly one pulse
    for (int k = 0; k < 12; k++) begin
      drive(k[0] ? 1'b0 : 1'b1, c0);
      wait_cyc(c0 + 7 + (k * 13) % (W - 20));
    end
    drive(1'b1, c0);
    exp_q.push_back(c0 + W + 2);
    wait_cyc(c0 + W + 1);
    check(btn_level == 1'b0, "R5 level held during burst settle", btn_level, 0);
    wait_cyc(c0 + W + 30);
    check(btn_level == 1'b1, "R5 burst accepted once", btn_level, 1);
    check(exp_q.size() == 0, "R5 single pulse consumed", exp_q.size(), 0);

    // release with bounce burst, no pulse
    for (int k = 0; k < 8; k++) begin
      drive(k[0] ? 1'b1 : 1'b0, c0);
      wait_cyc(c0 + 5 + k * 11);
    end
    drive(1'b0, c0);
    wait_cyc(c0 + W + 2);
    check(btn_level == 1'b0, "R7 bounced release accepted", btn_level, 0);
    wait_cyc(c0 + W + 30);

    // R4: excursion of exactly W cycles accepted
    drive(1'b1, c0);
    exp_q.push_back(c0 + W + 2);
    wait_cyc(c0 + W);
    drive(1'b0, c1);
    wait_cyc(c0 + W + 2);
    check(btn_level == 1'b1, "R4 exact window accepted", btn_level, 1);
    wait_cyc(c1 + W + 2);
    check(btn_level == 1'b0, "R7 follow-up release", btn_level, 0);
    wait_cyc(c1 + W + 20);
    check(exp_q.size() == 0, "R6 all expected presses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule